// File: doc/BRIEF.md
# HDB3 Line Code Violation Detector

This block watches a received bipolar line after HDB3 substitution. The line arrives as two strobes, one for positive pulses and one for negative pulses. Both are sampled on the recovered clock, one bit per clock. The block finds three kinds of error:

- **Zero runs:** four or more zeros in a row, which a correctly coded HDB3 line never carries.
- **Bipolar violations:** two successive marks of the same polarity.
- **Code violations:** a bipolar violation whose polarity repeats the polarity of the previous bipolar violation. HDB3 requires successive violations to alternate, so this is illegal.

Each error kind has its own enable input. Every enabled detection drives one shared error output, which pulses high for one clock per offending bit.

Zero-run checking and code-violation checking run only when E1 operation is active. E1 operation means the codec enable input is 1 and the 3-bit line-mode input holds 000. Bipolar-violation checking works in every mode. All settings are static input bits.

Top module: `hdb3_viol_det`

## Requirements
- R1: A synchronous active-high reset clears the zero-run count, the record of the last mark's polarity and the record of the last bipolar violation's polarity. `err_o` is low in the cycle after any clock edge at which reset was high. After reset, the first mark can never be a bipolar violation, and the first bipolar violation can never be a code violation.
- R2: `err_o` is registered. A violation found on the bit sampled at clock edge k drives `err_o` high from edge k until edge k+1. Each offending bit gives exactly one cycle high.
- R3: A bit is a mark when exactly one of `pos_i` and `neg_i` is 1. Any other combination, including both strobes high, is a zero. With zero-run detection active, the fourth consecutive zero is reported. Later zeros of the same run are not reported. The next mark ends the run, and after it a new run can be reported.
- R4: With `bpv_en_i` = 1, a mark with the same polarity as the previous mark is reported. Zeros between the two marks do not matter, and the line mode does not matter.
- R5: With `cv_en_i` = 1 and E1 active, a bipolar violation whose polarity equals that of the previous bipolar violation is reported. Violation history is tracked whatever the enable settings are.
- R6: E1 is active only when `codec_en_i` = 1 and `line_mode_i` = 3'b000. Otherwise, zero runs and code violations are never reported. While zero-run detection is not active (enable low or E1 inactive), the zero-run count is held at zero.
- R7: `err_o` is the OR of all enabled and active error kinds. A bit that breaks several rules at once gives a single one-cycle pulse.
- R8: With all three enables at 0, `err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | 1 | Positive-pulse strobe |
| neg_i | input | 1 | Negative-pulse strobe |
| codec_en_i | input | 1 | HDB3 codec enable |
| line_mode_i | input | 3 | Line mode code; 000 selects E1 |
| zrun_en_i | input | 1 | Zero-run detection enable |
| bpv_en_i | input | 1 | Bipolar violation detection enable |
| cv_en_i | input | 1 | Code violation detection enable |
| err_o | output | 1 | Merged one-cycle error pulse |

## Verification
The assertions check the following on every cycle:
- `err_o` is quiet after reset.
- `err_o` is quiet when all enables are off.
- `err_o` is quiet when E1 is inactive and bipolar checking is off.
- A mark never raises `err_o` unless bipolar or code checking is on.
- A zero never raises `err_o` unless zero-run checking is on.

Some behaviour needs history across many bits, and only the bench scenarios can show it:
- the exact fourth-zero timing and the single pulse per run;
- polarity memory across zeros;
- alternation of violation polarity;
- history being cleared by reset;
- the zero-run count being cleared while detection is inactive.

// File: rtl/hdb3_viol_det.sv
module hdb3_viol_det #(
  parameter int         ZRUN    = 4,
  parameter logic [2:0] E1_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pos_i,
  input  logic       neg_i,
  input  logic       codec_en_i,
  input  logic [2:0] line_mode_i,
  input  logic       zrun_en_i,
  input  logic       bpv_en_i,
  input  logic       cv_en_i,
  output logic       err_o
);
  localparam int CW = $clog2(ZRUN + 1);
  localparam logic [CW-1:0] ZLAST = CW'(ZRUN - 1);
  localparam logic [CW-1:0] ZSAT  = CW'(ZRUN);

  logic [CW-1:0] zcnt;
  logic          mark_seen, last_pol;
  logic          bpv_seen, bpv_pol;

  wire is_mark  = pos_i ^ neg_i;
  wire e1_on    = codec_en_i && (line_mode_i == E1_CODE);
  wire zrun_on  = zrun_en_i && e1_on;
  wire zrun_hit = zrun_on && !is_mark && (zcnt == ZLAST);
  wire bpv_hit  = is_mark && mark_seen && (pos_i == last_pol);
  wire cv_hit   = bpv_hit && bpv_seen && (pos_i == bpv_pol);
  wire any_hit  = zrun_hit || (bpv_hit && bpv_en_i) || (cv_hit && cv_en_i && e1_on);

  always_ff @(posedge clk) begin
    if (rst || !zrun_on || is_mark) zcnt <= '0;
    else if (zcnt != ZSAT)          zcnt <= zcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_seen <= 1'b0;
      last_pol  <= 1'b0;
    end else if (is_mark) begin
      mark_seen <= 1'b1;
      last_pol  <= pos_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bpv_seen <= 1'b0;
      bpv_pol  <= 1'b0;
    end else if (bpv_hit) begin
      bpv_seen <= 1'b1;
      bpv_pol  <= pos_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= any_hit;
  end
endmodule

// File: rtl/hdb3_viol_det_chk.sv
module hdb3_viol_det_chk (
  input logic       clk,
  input logic       rst,
  input logic       pos_i,
  input logic       neg_i,
  input logic       codec_en_i,
  input logic [2:0] line_mode_i,
  input logic       zrun_en_i,
  input logic       bpv_en_i,
  input logic       cv_en_i,
  input logic       err_o
);
  wire mark  = pos_i ^ neg_i;
  wire e1_ok = codec_en_i && (line_mode_i == 3'b000);

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !err_o);

  a_r8_all_off: assert property (@(posedge clk) disable iff (rst)
    (!zrun_en_i && !bpv_en_i && !cv_en_i) |=> !err_o);

  a_r6_mode_gate: assert property (@(posedge clk) disable iff (rst)
    (!e1_ok && !bpv_en_i) |=> !err_o);

  a_r3_mark_ends_run: assert property (@(posedge clk) disable iff (rst)
    (mark && !bpv_en_i && !cv_en_i) |=> !err_o);

  a_r4_zero_no_bpv: assert property (@(posedge clk) disable iff (rst)
    (!mark && !zrun_en_i) |=> !err_o);
endmodule

bind hdb3_viol_det hdb3_viol_det_chk u_chk (
  .clk(clk), .rst(rst), .pos_i(pos_i), .neg_i(neg_i),
  .codec_en_i(codec_en_i), .line_mode_i(line_mode_i),
  .zrun_en_i(zrun_en_i), .bpv_en_i(bpv_en_i), .cv_en_i(cv_en_i),
  .err_o(err_o)
);

// File: tb/hdb3_viol_det_tb.sv
module hdb3_viol_det_tb;
  logic clk = 0, rst = 1, pos_i = 0, neg_i = 0;
  logic codec_en_i = 1, zrun_en_i = 1, bpv_en_i = 1, cv_en_i = 1;
  logic [2:0] line_mode_i = 3'b000;
  logic err_o;
  int checks = 0, errors = 0;
  bit done = 0;

  int m_z; bit m_have, m_lp, m_hbv, m_lbv;

  always #4 clk = ~clk;

  hdb3_viol_det u_dut (.*);

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: err_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_z = 0; m_have = 0; m_lp = 0; m_hbv = 0; m_lbv = 0;
  endtask

  // caller is at a negedge; drives one bit and checks it at the next negedge
  task automatic send(string tag, bit p, bit n);
    bit mk, e1, zon, zh, bh, ch, exp;
    pos_i = p; neg_i = n;
    mk  = p ^ n;
    e1  = codec_en_i && line_mode_i == 3'b000;
    zon = zrun_en_i && e1;
    zh  = zon && !mk && m_z == 3;
    bh  = mk && m_have && p == m_lp;
    ch  = bh && m_hbv && p == m_lbv;
    exp = zh || (bh && bpv_en_i) || (ch && cv_en_i && e1);
    if (!zon || mk) m_z = 0; else if (m_z < 4) m_z++;
    if (mk) begin m_have = 1; m_lp = p; end
    if (bh) begin m_hbv = 1; m_lbv = p; end
    @(negedge clk);
    check(tag, err_o, exp);
  endtask

  task automatic do_reset();
    rst = 1; pos_i = 0; neg_i = 0;
    @(negedge clk);
    check("R1", err_o, 1'b0);
    rst = 0; model_reset();
  endtask

  task automatic cfg(bit c, bit [2:0] lm, bit z, bit b, bit v);
    codec_en_i = c; line_mode_i = lm; zrun_en_i = z; bpv_en_i = b; cv_en_i = v;
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    @(negedge clk); @(negedge clk);
    do_reset();
    // R3: exact fourth-zero timing and no repeat
    cfg(1, 3'b000, 1, 0, 0);
    send("R3", 1, 0);
    for (int i = 0; i < 8; i++) send("R3", 0, 0);
    send("R3", 0, 1);
    for (int i = 0; i < 3; i++) send("R3", 1, 1);
    send("R3", 0, 0);
    // R4: same polarity across zeros, any mode
    cfg(0, 3'b101, 0, 1, 0);
    send("R4", 1, 0); send("R4", 0, 0); send("R4", 0, 0); send("R4", 1, 0);
    send("R4", 0, 1); send("R4", 1, 0);
    // R5: alternating vs repeating violations
    cfg(1, 3'b000, 0, 0, 1);
    send("R5", 0, 1); send("R5", 0, 1); send("R5", 0, 1);
    send("R5", 1, 0); send("R5", 1, 0); send("R5", 0, 1); send("R5", 1, 0);
    // R6: E1 inactive suppresses zero runs and code violations, count held
    cfg(1, 3'b001, 1, 0, 1);
    for (int i = 0; i < 6; i++) send("R6", 0, 0);
    send("R6", 1, 0); send("R6", 1, 0); send("R6", 1, 0);
    cfg(0, 3'b000, 1, 0, 1);
    send("R6", 0, 0); send("R6", 0, 0); send("R6", 0, 0);
    cfg(1, 3'b000, 1, 0, 1);
    for (int i = 0; i < 5; i++) send("R6", 0, 0);
    // R1: reset clears polarity history
    cfg(1, 3'b000, 1, 1, 1);
    send("R1", 1, 0);
    do_reset();
    send("R1", 1, 0); send("R1", 1, 0); send("R1", 1, 0);
    // R7: bit breaking several rules gives one pulse
    send("R7", 1, 0); send("R7", 0, 0);
    // R8: all off
    cfg(1, 3'b000, 0, 0, 0);
    for (int i = 0; i < 6; i++) send("R8", 0, 0);
    send("R8", 1, 0); send("R8", 1, 0);
    // R2/R7: random segments
    for (int s = 0; s < 40; s++) begin
      cfg($urandom % 4 != 0, ($urandom % 3 == 0) ? 3'($urandom) : 3'b000,
          1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom % 10 == 0) do_reset();
      for (int b = 0; b < 200; b++) begin
        int r = $urandom % 16;
        if (r < 8)       send("R2", 0, 0);
        else if (r < 11) send("R7", 1, 0);
        else if (r < 14) send("R7", 0, 1);
        else if (r < 15) send("R3", 1, 1);
        else             send("R7", m_lp, !m_lp);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expected 1 actual 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule